// File: doc/BRIEF.md
# Timer Compare-Match Output Driver

This block watches a free-running timer and compares it with three compare registers. The timer itself is outside the block. The comparison happens only in a cycle where the timer reports a fresh increment. Each register that equals the new timer value raises a match.

One cycle after a match, two things happen together:
- The block sets that channel's interrupt flag.
- The match acts on an eight-bit output port.

Channel 0 drives port bits high in the low six-bit field. Channel 1 drives bits low in that same field. Channel 2 inverts the two upper bits. A separate enable mask chooses which bits each channel touches.

Software reaches the block through one register map. It uses this map to:
- load the compare values and the three masks;
- write the port directly;
- read the flags and a per-bit toggle record.

Software clears flags with a per-channel clear strobe. The interrupt output is high while any flag is set.

Top module: `cmpu_top`

## Requirements
- R1: A channel registers a match only in a cycle where `tmr_inc` is 1 and `tmr_val` equals its compare register. Equality is the only test, and a cycle without `tmr_inc` never matches.
- R2: A flag is set one cycle after the match cycle and not in the match cycle itself. Flag bit i is cleared by `flag_clr[i]`, but a flag being set in the same cycle takes precedence over the clear. `irq` is 1 exactly while any flag is 1.
- R3: One cycle after a channel 0 match, every port bit in 5..0 whose set-enable bit is 1 becomes 1.
- R4: One cycle after a channel 1 match, every port bit in 5..0 whose reset-enable bit is 1 becomes 0.
- R5: When channel 0 and channel 1 act on the same bit in the same cycle, the bit becomes 0.
- R6: One cycle after a channel 2 match, port bit 6+j is inverted for each toggle-enable bit j that is 1. Toggle-status bit j is inverted at the same time.
- R7: A write to address 6 loads the port. When a compare action lands in the same cycle, the bits that action touches take the hardware value and the other bits take the written value. The port holds its value when there is neither a write nor an action.
- R8: A compare value that the timer has already passed matches only after the timer wraps around and reaches it again.
- R9: After reset, the port, the flags, the toggle status, the masks and the compare registers are all 0, and `irq` is 0.
- R10: The register map is as follows:
  - addresses 0, 1 and 2 are compare registers 0, 1 and 2;
  - address 3 is set-enable in bits 5..0;
  - address 4 is reset-enable in bits 5..0;
  - address 5 is toggle-enable in bits 1..0;
  - address 6 is the port in bits 7..0;
  - address 7 (read only) holds the flags in bits 2..0 and the toggle status in bits 4..3.

  Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_val | input | TW | Current timer value |
| tmr_inc | input | 1 | Timer has just incremented to `tmr_val` |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write address |
| wr_data | input | TW | Write data |
| rd_sel | input | 3 | Read address |
| rd_data | output | TW | Read data, combinational |
| flag_clr | input | 3 | Per-channel flag clear strobe |
| port_out | output | PW | Output port |
| irq | output | 1 | Interrupt request, the OR of all flags |

## Verification
The bench builds the block with an eight-bit timer width (`TW=8`) and keeps the default eight-bit port with a six-bit set/reset field. With the narrow timer, a full wrap of the timer takes only 256 increments, so the passed-value case of R8 fits in a short directed sweep. The narrow timer width also makes it possible to check that masks read back truncated to their field widths.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  localparam int unsigned NCH = 3;
  localparam int unsigned CH_SET = 0;
  localparam int unsigned CH_CLR = 1;
  localparam int unsigned CH_TOG = 2;

  typedef enum logic [2:0] {
    SEL_CMP0  = 3'd0,
    SEL_CMP1  = 3'd1,
    SEL_CMP2  = 3'd2,
    SEL_SETEN = 3'd3,
    SEL_CLREN = 3'd4,
    SEL_TOGEN = 3'd5,
    SEL_PORT  = 3'd6,
    SEL_STAT  = 3'd7
  } sel_e;
endpackage

// File: rtl/cmpu_regs.sv
module cmpu_regs
  import cmpu_pkg::*;
#(
  parameter int unsigned TW   = 16,
  parameter int unsigned SR_N = 6,
  parameter int unsigned TG_N = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [2:0]               wr_sel,
  input  logic [TW-1:0]            wr_data,
  output logic [NCH-1:0][TW-1:0]   cmp_o,
  output logic [SR_N-1:0]          set_en_o,
  output logic [SR_N-1:0]          clr_en_o,
  output logic [TG_N-1:0]          tog_en_o
);
  logic [NCH-1:0][TW-1:0] cmp_q, cmp_n;
  logic [SR_N-1:0]        set_q, set_n, clr_q, clr_n;
  logic [TG_N-1:0]        tog_q, tog_n;

  always_comb begin
    cmp_n = cmp_q;
    set_n = set_q;
    clr_n = clr_q;
    tog_n = tog_q;
    if (wr_en) begin
      case (sel_e'(wr_sel))
        SEL_CMP0:  cmp_n[0] = wr_data;
        SEL_CMP1:  cmp_n[1] = wr_data;
        SEL_CMP2:  cmp_n[2] = wr_data;
        SEL_SETEN: set_n    = wr_data[SR_N-1:0];
        SEL_CLREN: clr_n    = wr_data[SR_N-1:0];
        SEL_TOGEN: tog_n    = wr_data[TG_N-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      set_q <= '0;
      clr_q <= '0;
      tog_q <= '0;
    end else if (wr_en) begin
      cmp_q <= cmp_n;
      set_q <= set_n;
      clr_q <= clr_n;
      tog_q <= tog_n;
    end
  end

  assign cmp_o    = cmp_q;
  assign set_en_o = set_q;
  assign clr_en_o = clr_q;
  assign tog_en_o = tog_q;

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cmp_q) && $stable(set_q) && $stable(clr_q) && $stable(tog_q))); // R10
endmodule

// File: rtl/cmpu_match.sv
module cmpu_match
  import cmpu_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TW-1:0]          tmr_val,
  input  logic                   tmr_inc,
  input  logic [NCH-1:0][TW-1:0] cmp_i,
  output logic [NCH-1:0]         match_o
);
  logic [NCH-1:0] hit_n;
  logic [NCH-1:0] match_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
    assign hit_n[ch] = tmr_inc && (tmr_val == cmp_i[ch]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= '0;
    else        match_q <= hit_n;
  end

  assign match_o = match_q;

  AST_MATCH_NEEDS_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (|match_q) |-> $past(tmr_inc)); // R1
endmodule

// File: rtl/cmpu_flags.sv
module cmpu_flags
  import cmpu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] match_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] flag_o,
  output logic           irq_o
);
  logic [NCH-1:0] flag_q, flag_n;

  always_comb begin
    flag_n = (flag_q & ~clr_i) | match_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_n;
  end

  assign flag_o = flag_q;
  assign irq_o  = |flag_q;

  AST_FLAG_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|match_i) |=> ((flag_q & $past(match_i)) == $past(match_i))); // R2
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~match_i)) |=> ((flag_q & $past(clr_i & ~match_i)) == '0)); // R2
endmodule

// File: rtl/cmpu_port.sv
module cmpu_port
  import cmpu_pkg::*;
#(
  parameter int unsigned PW   = 8,
  parameter int unsigned SR_N = 6,
  parameter int unsigned TG_N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  match_i,
  input  logic [SR_N-1:0] set_en_i,
  input  logic [SR_N-1:0] clr_en_i,
  input  logic [TG_N-1:0] tog_en_i,
  input  logic            sw_we_i,
  input  logic [PW-1:0]   sw_val_i,
  output logic [PW-1:0]   port_o,
  output logic [TG_N-1:0] tstat_o
);
  logic [PW-1:0]   port_q, port_n;
  logic [TG_N-1:0] tstat_q, tstat_n;
  logic [PW-1:0]   set_m, clr_m, tog_m, hw_mask, hw_val, base;

  always_comb begin
    set_m   = match_i[CH_SET] ? {{TG_N{1'b0}}, set_en_i} : '0;
    clr_m   = match_i[CH_CLR] ? {{TG_N{1'b0}}, clr_en_i} : '0;
    tog_m   = match_i[CH_TOG] ? {tog_en_i, {SR_N{1'b0}}} : '0;
    hw_mask = set_m | clr_m | tog_m;
    hw_val  = (set_m & ~clr_m) | (tog_m & ~port_q);
    base    = sw_we_i ? sw_val_i : port_q;
    port_n  = (base & ~hw_mask) | (hw_val & hw_mask);
    tstat_n = tstat_q ^ (match_i[CH_TOG] ? tog_en_i : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q  <= '0;
      tstat_q <= '0;
    end else begin
      port_q  <= port_n;
      tstat_q <= tstat_n;
    end
  end

  assign port_o  = port_q;
  assign tstat_o = tstat_q;

  AST_SET_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_m & ~clr_m)) |=> ((port_q & $past(set_m & ~clr_m)) == $past(set_m & ~clr_m))); // R3
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_m) |=> ((port_q & $past(clr_m)) == '0)); // R5
  AST_TOGGLE_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (|tog_m) |=> ((port_q & $past(tog_m)) == ($past(~port_q) & $past(tog_m)))); // R6
  AST_PORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we_i && (hw_mask == '0)) |=> $stable(port_q)); // R7
endmodule

// File: rtl/cmpu_top.sv
module cmpu_top
  import cmpu_pkg::*;
#(
  parameter int unsigned TW   = 16,
  parameter int unsigned PW   = 8,
  parameter int unsigned SR_N = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  tmr_val,
  input  logic           tmr_inc,
  input  logic           wr_en,
  input  logic [2:0]     wr_sel,
  input  logic [TW-1:0]  wr_data,
  input  logic [2:0]     rd_sel,
  output logic [TW-1:0]  rd_data,
  input  logic [2:0]     flag_clr,
  output logic [PW-1:0]  port_out,
  output logic           irq
);
  localparam int unsigned TG_N = PW - SR_N;

  logic [NCH-1:0][TW-1:0] cmp;
  logic [SR_N-1:0]        set_en, clr_en;
  logic [TG_N-1:0]        tog_en, tstat;
  logic [NCH-1:0]         match, flags;
  logic                   sw_we;

  assign sw_we = wr_en && (sel_e'(wr_sel) == SEL_PORT);

  cmpu_regs #(.TW(TW), .SR_N(SR_N), .TG_N(TG_N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmp_o(cmp), .set_en_o(set_en), .clr_en_o(clr_en), .tog_en_o(tog_en)
  );

  cmpu_match #(.TW(TW)) u_match (
    .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .tmr_inc(tmr_inc),
    .cmp_i(cmp), .match_o(match)
  );

  cmpu_flags u_flags (
    .clk(clk), .rst_n(rst_n), .match_i(match), .clr_i(flag_clr),
    .flag_o(flags), .irq_o(irq)
  );

  cmpu_port #(.PW(PW), .SR_N(SR_N), .TG_N(TG_N)) u_port (
    .clk(clk), .rst_n(rst_n), .match_i(match), .set_en_i(set_en),
    .clr_en_i(clr_en), .tog_en_i(tog_en), .sw_we_i(sw_we),
    .sw_val_i(wr_data[PW-1:0]), .port_o(port_out), .tstat_o(tstat)
  );

  always_comb begin
    rd_data = '0;
    case (sel_e'(rd_sel))
      SEL_CMP0:  rd_data = cmp[0];
      SEL_CMP1:  rd_data = cmp[1];
      SEL_CMP2:  rd_data = cmp[2];
      SEL_SETEN: rd_data[SR_N-1:0] = set_en;
      SEL_CLREN: rd_data[SR_N-1:0] = clr_en;
      SEL_TOGEN: rd_data[TG_N-1:0] = tog_en;
      SEL_PORT:  rd_data[PW-1:0]   = port_out;
      SEL_STAT:  rd_data[NCH+TG_N-1:0] = {tstat, flags};
      default:   rd_data = '0;
    endcase
  end

  AST_IRQ_FROM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|match)); // R2
endmodule

// File: tb/cmpu_top_bench.sv
module cmpu_top_bench;
  localparam int TW = 8;
  logic          clk = 1'b0;
  logic          rst_n;
  logic [TW-1:0] tmr_val;
  logic          tmr_inc;
  logic          wr_en;
  logic [2:0]    wr_sel;
  logic [TW-1:0] wr_data;
  logic [2:0]    rd_sel;
  logic [TW-1:0] rd_data;
  logic [2:0]    flag_clr;
  logic [7:0]    port_out;
  logic          irq;
  int            n_run = 0;
  int            n_fail = 0;

  always #5 clk = ~clk;

  cmpu_top #(.TW(TW)) u_cmpu_top (
    .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .tmr_inc(tmr_inc),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .flag_clr(flag_clr), .port_out(port_out), .irq(irq)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(a); wr_data = TW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    rd_sel = 3'(a);
    #1;
    v = int'(rd_data);
  endtask

  // drive one matching increment; returns at the negedge after the match cycle
  task automatic pulse(int v);
    @(negedge clk);
    tmr_val = TW'(v); tmr_inc = 1'b1;
    @(negedge clk);
    tmr_inc = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 3'b111;
    @(negedge clk); flag_clr = 3'b000;
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk("R9", $sformatf("reset read addr %0d", a), v, 0);
    end
    chk("R9", "reset irq", int'(irq), 0);
  endtask

  task automatic t_regmap();
    int v;
    wr(0, 'h11); wr(1, 'h22); wr(2, 'h33);
    wr(3, 'hFF); wr(4, 'h15); wr(5, 'hFE);
    rd(0, v); chk("R10", "cmp0 readback", v, 'h11);
    rd(1, v); chk("R10", "cmp1 readback", v, 'h22);
    rd(2, v); chk("R10", "cmp2 readback", v, 'h33);
    rd(3, v); chk("R10", "set-enable truncated", v, 'h3F);
    rd(4, v); chk("R10", "reset-enable readback", v, 'h15);
    rd(5, v); chk("R10", "toggle-enable truncated", v, 'h2);
    wr(3, 'h05); wr(4, 0); wr(5, 0);
  endtask

  task automatic t_inc_gate();
    int v;
    wr(0, 'h10);
    @(negedge clk); tmr_val = 8'h10; tmr_inc = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(7, v); chk("R1", "no match without increment", v, 0);
    chk("R1", "port untouched without increment", int'(port_out), 0);
    pulse('h11); @(negedge clk);
    rd(7, v); chk("R1", "no match on unequal value", v, 0);
    pulse('h10);
    rd(7, v); chk("R2", "flag not yet set in match cycle", v, 0);
    chk("R2", "port not yet changed", int'(port_out), 0);
    @(negedge clk);
    rd(7, v); chk("R2", "flag0 set one cycle later", v, 1);
    chk("R3", "set-enable bits driven high", int'(port_out), 'h05);
    chk("R2", "irq high with flag", int'(irq), 1);
  endtask

  task automatic t_flag_clear();
    int v;
    clear_flags();
    rd(7, v); chk("R2", "flags cleared", v, 0);
    chk("R2", "irq low after clear", int'(irq), 0);
    pulse('h10);
    flag_clr = 3'b001;
    @(negedge clk); flag_clr = 3'b000;
    rd(7, v); chk("R2", "set beats simultaneous clear", v & 7, 1);
    clear_flags();
  endtask

  task automatic t_reset_bits();
    int v;
    wr(4, 'h01); wr(1, 'h20);
    pulse('h20); @(negedge clk);
    chk("R4", "reset-enable bit driven low", int'(port_out), 'h04);
    rd(7, v); chk("R4", "flag1 set", v, 2);
    clear_flags();
  endtask

  task automatic t_priority();
    wr(3, 'h3F); wr(4, 'h03); wr(0, 'h30); wr(1, 'h30);
    pulse('h30); @(negedge clk);
    chk("R5", "reset wins over set", int'(port_out), 'h3C);
    clear_flags();
  endtask

  task automatic t_toggle();
    int v;
    wr(5, 'h3); wr(2, 'h40);
    pulse('h40); @(negedge clk);
    chk("R6", "both upper bits toggled", int'(port_out), 'hFC);
    rd(7, v); chk("R6", "status flag2 and toggle status 11", v, 'h1C);
    clear_flags();
    wr(5, 'h1);
    pulse('h40); @(negedge clk);
    chk("R6", "only bit 6 toggled", int'(port_out), 'hBC);
    rd(7, v); chk("R6", "toggle status 10", v, 'h14);
    clear_flags();
  endtask

  task automatic t_sw_write();
    int v;
    wr(6, 'h00);
    chk("R7", "direct port write", int'(port_out), 0);
    wr(3, 'h3F); wr(4, 0); wr(5, 0);
    pulse('h30);
    wr_en = 1'b1; wr_sel = 3'd6; wr_data = 8'h80;
    @(negedge clk); wr_en = 1'b0;
    chk("R7", "hardware bits override write, others written", int'(port_out), 'hBF);
    rd(6, v); chk("R10", "port readback", v, 'hBF);
    repeat (3) @(negedge clk);
    chk("R7", "port holds when idle", int'(port_out), 'hBF);
    clear_flags();
  endtask

  task automatic t_wrap();
    int v;
    wr(0, 'h05);
    for (int k = 'h51; k <= 'h104; k++) begin
      @(negedge clk); tmr_val = k[7:0]; tmr_inc = 1'b1;
    end
    @(negedge clk); tmr_inc = 1'b0;
    @(negedge clk);
    rd(7, v); chk("R8", "passed value not matched before wrap", v & 1, 0);
    pulse('h05); @(negedge clk);
    rd(7, v); chk("R8", "matched after wrap", v & 1, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tmr_val = '0; tmr_inc = 1'b0; wr_en = 1'b0;
    wr_sel = '0; wr_data = '0; rd_sel = '0; flag_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_inc_gate();
    t_flag_clear();
    t_reset_bits();
    t_priority();
    t_toggle();
    t_sw_write();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule